// File: doc/BRIEF.md
# AHB Byte-Lane RAM Slave

This block is an AHB slave in front of a synchronous on-chip memory of 32-bit words. The storage is four separate byte-wide lanes, so a byte or halfword write changes only the bytes it addresses. The slave answers inside a 1 MB window. Bits 31:20 of the address select the window, and the reset value of the base parameter is 0xA00, which places the window at 0xA0000000. Inside the window, the low address bits wrap onto the configured number of words.

A read takes the memory in the address phase, so its data is ready in the data phase with no wait state. A write holds its address and lane mask in the address phase. The memory is written at the close of the data phase, once the write data is on the bus.

Back-pressure follows the AHB handshake. The slave takes a new address phase only while `hready_in` is high. It pulls `hready_out` low only in one case: the data phase of a read whose address phase fell on the data phase of a write to the same word. The read is then held for one cycle while the write lands, and it returns the new contents. Transfers of type IDLE or BUSY, and transfers outside the window, are answered OKAY and leave the memory as it was. The burst type is accepted but has no effect, because every NONSEQ or SEQ beat carries its own address.

Top module: `ahb_ram_slave`

## Requirements
- R1: After reset, `hready_out` is 1 and `hresp` is 0 (OKAY).
- R2: A single read returns the stored word on `hrdata` in the data phase that follows its address phase, with `hready_out` high throughout.
- R3: The data phase of a write never has `hready_out` low, and the word is stored from `hwdata` sampled at the end of that data phase.
- R4: A byte write (`hsize`=0) updates only lane `haddr[1:0]`, where lane 0 is `hrdata/hwdata[31:24]`, lane 1 is [23:16], lane 2 is [15:8] and lane 3 is [7:0].
- R5: A halfword write (`hsize`=1) updates bits [31:16] when `haddr[1]`=0 and bits [15:0] when `haddr[1]`=1. The other half is left as it was.
- R6: A read whose address phase falls on the data phase of a write to the same word gets exactly one wait state, and it then returns the newly written contents.
- R7: A read right after a write to a different word gets no wait state.
- R8: An IDLE (`htrans`=0) or BUSY (`htrans`=1) transfer with `hwrite`=1 gets OKAY with `hready_out` high, and it changes no memory contents.
- R9: A transfer whose `haddr[31:20]` differs from the base parameter changes no memory contents.
- R10: Back-to-back NONSEQ (`htrans`=2) and SEQ (`htrans`=3) beats are accepted one per cycle for any `hburst` value, and reads in such a run return one word per cycle.
- R11: The word index is `haddr[WORD_AW+1:2]`. Higher bits inside the window are ignored, so addresses that differ only in those bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| hburst | input | 3 | Burst type, accepted and unused |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus ready, the end of the current data phase |
| hready_out | output | 1 | Slave ready |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | 32 | Read data |

## Verification
The bench builds the slave with `WORD_AW`=4, a 16-word memory, which is small enough to sweep every word, every byte lane and both halfword positions. It keeps its own model of the words and follows each data phase with a read of the same word, so that the single wait state is seen on every lane pattern. It also runs reads from the next word to show that a different word costs no wait state. With only 16 words, addresses one to three steps of 64 bytes higher land inside the window, and so the wrap-around of the word index can be tested. Writes outside the window, IDLE beats and BUSY beats are each followed by a read-back of the word they could have changed.

// File: rtl/ahb_ram_pkg.sv
package ahb_ram_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam int LANES     = 4;
  localparam int LANE_BITS = 8;

  // Lane l carries data bits [31-8l -: 8] (big-endian byte order).
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz,
                                                 input logic [1:0] a);
    logic [LANES-1:0] m;
    case (sz)
      3'd0:    m = 4'b0001 << a;
      3'd1:    m = a[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ahb_ram_lane.sv
module ahb_ram_lane #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ahb_ram_ctrl.sv
module ahb_ram_ctrl
  import ahb_ram_pkg::*;
#(
  parameter int          AW   = 8,
  parameter logic [11:0] BASE = 12'hA00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsel,
  input  logic [31:0]      haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic             hready_in,
  output logic             hready_out,
  output logic             wr_en,
  output logic [LANES-1:0] wr_mask,
  output logic [AW-1:0]    wr_addr,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr
);

  logic          win_hit, acc, acc_rd, acc_wr;
  logic [AW-1:0] word;
  logic          wp_q, stall_q;
  logic [AW-1:0] wa_q, ra_q;
  logic [LANES-1:0] wm_q;
  logic          unused_hi;

  assign unused_hi = ^haddr[19:AW+2];

  assign win_hit = (haddr[31:20] == BASE);
  assign acc     = hsel && hready_in && htrans[1] && win_hit;
  assign acc_rd  = acc && !hwrite;
  assign acc_wr  = acc && hwrite;
  assign word    = haddr[AW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= 1'b0;
      stall_q <= 1'b0;
      wa_q    <= '0;
      ra_q    <= '0;
      wm_q    <= '0;
    end else if (hready_in) begin
      wp_q    <= acc_wr;
      stall_q <= acc_rd && wp_q && (wa_q == word);
      if (acc_wr) begin
        wa_q <= word;
        wm_q <= lane_mask(hsize, haddr[1:0]);
      end
      if (acc_rd) ra_q <= word;
    end else begin
      stall_q <= 1'b0;
    end
  end

  assign hready_out = !stall_q;
  assign wr_en      = wp_q && hready_in;
  assign wr_mask    = wm_q;
  assign wr_addr    = wa_q;
  assign rd_en      = acc_rd || stall_q;
  assign rd_addr    = stall_q ? ra_q : word;

  // R3: a write data phase is never stretched
  p_write_no_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |-> hready_out);

  // R6: a wait state only follows a pending write
  p_stall_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_out |-> $past(wp_q));

  // R6: the wait lasts one cycle when the bus ready follows this slave
  p_stall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_out && !hready_in) |=> hready_out);

  // R5: a halfword write enables exactly two lanes
  p_half_two_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && hsize == 3'd1) |=> ($countones(wr_mask) == 2));

  // R8: memory is written only for an accepted write address phase
  p_write_needs_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(acc_wr));

endmodule

// File: rtl/ahb_ram_slave.sv
module ahb_ram_slave
  import ahb_ram_pkg::*;
#(
  parameter int          WORD_AW = 8,
  parameter logic [11:0] BASE    = 12'hA00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [2:0]  hburst,
  input  logic [31:0] hwdata,
  input  logic        hready_in,
  output logic        hready_out,
  output logic [1:0]  hresp,
  output logic [31:0] hrdata
);

  logic               wr_en, rd_en;
  logic [LANES-1:0]   wr_mask;
  logic [WORD_AW-1:0] wr_addr, rd_addr;
  logic               unused_burst;

  assign unused_burst = ^hburst;
  assign hresp        = 2'b00;

  ahb_ram_ctrl #(.AW(WORD_AW), .BASE(BASE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsel       (hsel),
    .haddr      (haddr),
    .htrans     (htrans),
    .hwrite     (hwrite),
    .hsize      (hsize),
    .hready_in  (hready_in),
    .hready_out (hready_out),
    .wr_en      (wr_en),
    .wr_mask    (wr_mask),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = 31 - LANE_BITS * l;
    ahb_ram_lane #(.AW(WORD_AW), .DW(LANE_BITS)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && wr_mask[l]),
      .waddr (wr_addr),
      .wdata (hwdata[HI -: LANE_BITS]),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (hrdata[HI -: LANE_BITS])
    );
  end

endmodule

// File: tb/ahb_ram_slave_bench.sv
module ahb_ram_slave_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WA = 4;
  localparam int NW = 1 << WA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'd0;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [2:0]  hburst = 3'd0;
  logic [31:0] hwdata = '0;
  logic        hready_out;
  logic [1:0]  hresp;
  logic [31:0] hrdata;

  always #2.5 clk = ~clk;

  ahb_ram_slave #(.WORD_AW(WA), .BASE(12'hA00)) u_ahb_ram_slave (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready_in(hready_out), .hready_out(hready_out), .hresp(hresp),
    .hrdata(hrdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow [NW];

  // transfer currently in its data phase
  bit          dp_v = 0, dp_w = 0, dp_st = 0;
  logic [31:0] dp_a = '0, dp_wd = '0;
  logic [2:0]  dp_sz = '0;
  string       dp_tag = "";

  localparam logic [31:0] BASEA = 32'hA000_0000;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_write(input logic [31:0] a, input logic [2:0] sz,
                             input logic [31:0] wd);
    int w = int'(a[WA+1:2]);
    for (int l = 0; l < 4; l++) begin
      bit en = (sz == 0) ? (l == int'(a[1:0])) :
               (sz == 1) ? ((l / 2) == int'(a[1])) : 1'b1;
      if (en) shadow[w][31-8*l -: 8] = wd[31-8*l -: 8];
    end
  endtask

  // called at a negedge; drives a new address phase, finishes the data phase
  task automatic issue(input logic [1:0] tr, input bit w, input logic [31:0] a,
                       input logic [2:0] sz, input logic [2:0] bu,
                       input logic [31:0] wd, input string tag);
    bit nv, nst;
    int stalls = 0;
    hsel = 1'b1; htrans = tr; hwrite = w; haddr = a; hsize = sz; hburst = bu;
    hwdata = dp_wd;
    nv  = tr[1] && (a[31:20] == 12'hA00);
    nst = nv && !w && dp_v && dp_w && (dp_a[WA+1:2] == a[WA+1:2]);
    while (!hready_out && stalls < 4) begin
      stalls++;
      @(negedge clk);
    end
    if (dp_v) begin
      if (dp_w) begin
        chk(stalls == 0, {dp_tag, " write wait"}, stalls, 0);
        apply_write(dp_a, dp_sz, dp_wd);
      end else begin
        chk(stalls == int'(dp_st), {dp_tag, " wait states"}, stalls, dp_st);
        chk(hrdata === shadow[dp_a[WA+1:2]], {dp_tag, " read data"},
            hrdata, shadow[dp_a[WA+1:2]]);
      end
    end
    @(negedge clk);
    dp_v = nv; dp_w = w; dp_a = a; dp_sz = sz; dp_wd = wd; dp_st = nst;
    dp_tag = tag;
  endtask

  task automatic idle();
    issue(2'd0, 1'b0, BASEA, 3'd2, 3'd0, 32'h0, "idle");
  endtask

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h0103_0507) ^ 32'hA55A_3CC3;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(hready_out === 1'b1, "R1 hready", hready_out, 1);
    chk(hresp === 2'b00, "R1 hresp", hresp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hready_out === 1'b1 && hresp === 2'b00, "R1 after release",
        {hready_out, hresp}, 3'b100);

    // word fill as an INCR16 write burst, then SEQ read burst (R3, R10)
    for (int k = 0; k < NW; k++)
      issue(k == 0 ? 2'd2 : 2'd3, 1'b1, BASEA + 32'(4*k), 3'd2, 3'd7, pat(k), "R3");
    for (int k = 0; k < NW; k++)
      issue(k == 0 ? 2'd2 : 2'd3, 1'b0, BASEA + 32'(4*k), 3'd2, 3'd1, 0, "R10");
    idle();

    // single reads separated by idle (R2)
    for (int k = 0; k < NW; k += 3) begin
      issue(2'd2, 1'b0, BASEA + 32'(4*k), 3'd2, 3'd0, 0, "R2");
      idle();
    end

    // byte sweep, each followed by a same-word read (R4, R6)
    for (int w = 0; w < NW; w++)
      for (int l = 0; l < 4; l++) begin
        logic [31:0] d = 32'hEEEE_EEEE;
        d[31-8*l -: 8] = 8'(w * 4 + l + 8'h40);
        issue(2'd2, 1'b1, BASEA + 32'(4*w + l), 3'd0, 3'd0, d, "R4");
        issue(2'd2, 1'b0, BASEA + 32'(4*w), 3'd0, 3'd0, 0, "R4 R6");
      end
    idle();

    // halfword sweep; read of next word (R7) then same word (R5)
    for (int w = 0; w < NW; w++)
      for (int h = 0; h < 2; h++) begin
        logic [31:0] d = h ? {16'hDDDD, 16'(w * 37 + 5)} : {16'(w * 91 + 3), 16'hDDDD};
        issue(2'd2, 1'b1, BASEA + 32'(4*w + 2*h), 3'd1, 3'd0, d, "R5");
        issue(2'd2, 1'b0, BASEA + 32'(4*((w + 1) % NW)), 3'd2, 3'd0, 0, "R7");
        issue(2'd2, 1'b0, BASEA + 32'(4*w), 3'd2, 3'd0, 0, "R5");
      end
    idle();

    // IDLE and BUSY with hwrite high (R8)
    for (int k = 0; k < 4; k++) begin
      issue(2'(k % 2), 1'b1, BASEA + 32'(4*k), 3'd2, 3'd0, 32'hBAD0_0000, "R8");
      chk(hready_out === 1'b1 && hresp === 2'b00, "R8 okay",
          {hready_out, hresp}, 3'b100);
      issue(2'(k % 2), 1'b1, BASEA + 32'(4*k), 3'd2, 3'd0, 32'hBAD0_0001, "R8");
      issue(2'd2, 1'b0, BASEA + 32'(4*k), 3'd2, 3'd0, 0, "R8");
      idle();
    end

    // outside the window (R9)
    for (int k = 0; k < NW; k += 5) begin
      issue(2'd2, 1'b1, 32'hB000_0000 + 32'(4*k), 3'd2, 3'd0, 32'h0BAD_F00D, "R9");
      issue(2'd2, 1'b1, 32'h9FF0_0000 + 32'(4*k), 3'd2, 3'd0, 32'h0BAD_F00E, "R9");
      idle();
      issue(2'd2, 1'b0, BASEA + 32'(4*k), 3'd2, 3'd0, 0, "R9");
      idle();
    end

    // aliasing of higher window bits (R11)
    for (int m = 1; m < 4; m++)
      for (int k = 0; k < NW; k += 4) begin
        issue(2'd2, 1'b1, BASEA + 32'(64*m + 4*k), 3'd2, 3'd0, pat(k + 100*m), "R11");
        idle();
        issue(2'd2, 1'b0, BASEA + 32'(4*k), 3'd2, 3'd0, 0, "R11");
        idle();
      end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule